// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the host-facing register set of one IDE-style bus-master DMA channel. It holds three registers: a command byte, a status byte and a 32-bit base address for the descriptor table. A byte-addressed register port reaches all three with 1-, 2- or 4-byte accesses. The block does not walk descriptors. It tells a separate walker engine when to start and when to cancel, and it gives the walker the current descriptor pointer and the transfer direction. The walker reports back when it goes idle, whether more work is pending, and any error.

The start/stop control acts only when the start bit changes value. When the start bit goes from 0 to 1, the descriptor pointer is reloaded from the table base. If the channel was not already active, the walker is also kicked. When the start bit goes from 1 to 0, a cancel is sent to the walker. The drive interrupt passes through to the host unchanged. A rising edge on it is also recorded in status, where software clears it by writing 1.

Register image by byte offset:

| Offset | Contents |
|---|---|
| 0 | command |
| 1 | reads 0 |
| 2 | status |
| 3 | reads 0 |
| 4 to 7 | table base, little-endian |

An access of width W at offset A covers bytes A to A+W-1. Data is aligned to bit 0 of the port. Bytes past offset 7 are dropped.

Top module: `bmdma_ctrl_regs`

## Requirements
- R1: While `rst` is high, `walker_cancel` is high if the channel was active. After a reset edge, command, status, table base and `desc_ptr` all read as 0.
- R2: The command byte keeps only bit 0 (start) and bit 3 (direction). All other bits read back as 0. `dir_to_mem` equals command bit 3.
- R3: A command write that leaves the start bit at its old value produces no `walker_start` or `walker_cancel` pulse. It also leaves the active bit and `desc_ptr` unchanged.
- R4: A command write that moves start from 0 to 1 loads `desc_ptr` with the table base as it stood before the write. If status bit 0 (active) was clear, it sets that bit, and `walker_start` is high for exactly the one cycle after the write edge.
- R5: A command write that moves start from 1 to 0 clears the active bit, and `walker_cancel` is high for exactly the one cycle after the write edge.
- R6: A table-base write replaces only the addressed bytes, and bits 1:0 of the base are always stored as 0.
- R7: A read at offset A of width W (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) returns the register image shifted right by 8×A bits and masked to W bytes.
- R8: `irq_out` follows `irq_in` in the same cycle. A 0-to-1 change of `irq_in` sets status bit 2. A 1-to-0 change leaves that bit as it is.
- R9: Writing 1 to status bit 2 or to status bit 1 clears that bit, and writing 0 to either has no effect. Status bits 5 and 6 are plain read/write. Bit 0 cannot be written. Bits 3, 4 and 7 read as 0.
- R10: A `walker_inactive` pulse sets the active bit to the value of `walker_more`.
- R11: A `walker_error` pulse sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Byte offset of the access |
| reg_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| reg_wdata | input | 32 | Write data, aligned to bit 0 |
| reg_rdata | output | 32 | Combinational read data for reg_addr/reg_size |
| dir_to_mem | output | 1 | Command bit 3, transfer direction |
| desc_ptr | output | 32 | Current descriptor pointer |
| walker_start | output | 1 | One-cycle start request |
| walker_cancel | output | 1 | Cancel request |
| walker_inactive | input | 1 | Walker has gone idle |
| walker_more | input | 1 | With walker_inactive: more transfers pending |
| walker_error | input | 1 | Walker error pulse |
| irq_in | input | 1 | Drive interrupt |
| irq_out | output | 1 | Interrupt to host |

## Verification
Suppose the stored start bit drifted from the value last written. The next command write would then take the wrong branch, and the first register access after it would show a spurious or missing one-cycle start or cancel pulse. A wrong lane enable or a wrong alignment mask in the base register would show up on the next read of any covering offset and width. For that reason every write is followed by a sweep of reads over all offsets and sizes. Interrupt-latch faults show as a status read error one cycle after the edge on `irq_in`.

// File: rtl/bmdma_regs_pkg.sv
package bmdma_regs_pkg;

    localparam int PTR_W      = 32;
    localparam int DATA_W     = 32;
    localparam int BASE_OFS   = 4;
    localparam int BASE_BYTES = PTR_W / 8;
    localparam int LANES      = BASE_OFS + BASE_BYTES;
    localparam int OFS_W      = $clog2(LANES);
    localparam int CMD_OFS    = 0;
    localparam int STAT_OFS   = 2;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam logic [7:0] CMD_KEEP = 8'h09;

    localparam int ST_ACTIVE = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_INT    = 2;
    localparam int ST_FLAG_LO = 5;
    localparam int ST_FLAG_HI = 6;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [LANES-1:0]   en;
        logic [LANES*8-1:0] data;
    } lane_wr_t;

    function automatic int size_bytes(acc_size_e sz);
        case (sz)
            ACC_BYTE: return 1;
            ACC_HALF: return 2;
            ACC_WORD: return 4;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_enables(logic [OFS_W-1:0] ofs,
                                                      acc_size_e sz);
        logic [LANES-1:0] en;
        int lo;
        int hi;
        lo = int'(ofs);
        hi = lo + size_bytes(sz);
        for (int b = 0; b < LANES; b++) begin
            en[b] = (b >= lo) && (b < hi);
        end
        return en;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(acc_size_e sz);
        case (sz)
            ACC_BYTE: return 32'h0000_00FF;
            ACC_HALF: return 32'h0000_FFFF;
            ACC_WORD: return 32'hFFFF_FFFF;
            default:  return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/bmdma_lane_dec.sv
module bmdma_lane_dec
    import bmdma_regs_pkg::*;
(
    input  logic                  wr_req,
    input  logic [OFS_W-1:0]      ofs,
    input  acc_size_e             size,
    input  logic [DATA_W-1:0]     wdata,
    output lane_wr_t              lanes
);
    localparam int WIDE = LANES * 8;

    logic [WIDE-1:0] shifted;
    logic [LANES-1:0] en_raw;

    always_comb begin
        shifted = {{(WIDE-DATA_W){1'b0}}, wdata} << (8 * int'(ofs));
        en_raw  = lane_enables(ofs, size);
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lanes.en[b]           = wr_req & en_raw[b];
        assign lanes.data[b*8 +: 8]  = shifted[b*8 +: 8];
    end
endmodule

// File: rtl/bmdma_base_reg.sv
module bmdma_base_reg
    import bmdma_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BASE_BYTES-1:0] byte_en,
    input  logic [PTR_W-1:0]      byte_data,
    output logic [PTR_W-1:0]      base
);
    for (genvar i = 0; i < BASE_BYTES; i++) begin : g_byte
        localparam logic [7:0] KEEP = (i == 0) ? 8'hFC : 8'hFF;
        always_ff @(posedge clk) begin
            if (rst) begin
                base[i*8 +: 8] <= 8'h00;
            end else if (byte_en[i]) begin
                base[i*8 +: 8] <= byte_data[i*8 +: 8] & KEEP;
            end
        end
    end

    // R6
    base_align_chk: assert property (@(posedge clk) disable iff (rst)
        base[1:0] == 2'b00);
endmodule

// File: rtl/bmdma_cmd_unit.sv
module bmdma_cmd_unit
    import bmdma_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic [PTR_W-1:0] base,
    input  logic             walker_inactive,
    input  logic             walker_more,
    output logic [7:0]       cmd,
    output logic             active,
    output logic             start_req,
    output logic             cancel_req,
    output logic [PTR_W-1:0] cur_ptr
);
    logic start_old;
    logic start_new;
    logic go_edge;
    logic stop_edge;

    always_comb begin
        start_old = cmd[CMD_START_BIT];
        start_new = wr_byte[CMD_START_BIT];
        go_edge   = wr_en && start_new && !start_old;
        stop_edge = wr_en && !start_new && start_old;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd        <= 8'h00;
            active     <= 1'b0;
            start_req  <= 1'b0;
            cancel_req <= 1'b0;
            cur_ptr    <= '0;
        end else begin
            start_req  <= 1'b0;
            cancel_req <= 1'b0;
            if (walker_inactive) begin
                active <= walker_more;
            end
            if (wr_en) begin
                cmd <= wr_byte & CMD_KEEP;
            end
            if (go_edge) begin
                cur_ptr <= base;
                if (!active) begin
                    active    <= 1'b1;
                    start_req <= 1'b1;
                end
            end
            if (stop_edge) begin
                cancel_req <= 1'b1;
                active     <= 1'b0;
            end
        end
    end

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_req |-> (active && cmd[CMD_START_BIT]));

    // R4
    ptr_reload_chk: assert property (@(posedge clk) disable iff (rst)
        start_req |-> (cur_ptr == $past(base)));

    // R5
    cancel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_req |-> (!active && !cmd[CMD_START_BIT]));

    // R3
    no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_req && cancel_req));
endmodule

// File: rtl/bmdma_status_unit.sv
module bmdma_status_unit
    import bmdma_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       active,
    input  logic       irq_in,
    input  logic       walker_error,
    output logic [7:0] status
);
    logic       err_q;
    logic       int_q;
    logic [1:0] flags_q;
    logic       irq_q;
    logic       irq_rise;
    logic       clr_err;
    logic       clr_int;

    always_comb begin
        irq_rise = irq_in && !irq_q;
        clr_err  = wr_en && wr_byte[ST_ERR];
        clr_int  = wr_en && wr_byte[ST_INT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= 1'b0;
            int_q   <= 1'b0;
            flags_q <= 2'b00;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= irq_in;
            err_q <= (err_q && !clr_err) || walker_error;
            int_q <= (int_q && !clr_int) || irq_rise;
            if (wr_en) begin
                flags_q <= wr_byte[ST_FLAG_HI:ST_FLAG_LO];
            end
        end
    end

    always_comb begin
        status                         = 8'h00;
        status[ST_ACTIVE]              = active;
        status[ST_ERR]                 = err_q;
        status[ST_INT]                 = int_q;
        status[ST_FLAG_HI:ST_FLAG_LO]  = flags_q;
    end

    // R8
    int_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_in) |=> int_q);

    // R11
    err_on_report_chk: assert property (@(posedge clk) disable iff (rst)
        walker_error |=> err_q);
endmodule

// File: rtl/bmdma_ctrl_regs.sv
module bmdma_ctrl_regs
    import bmdma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dir_to_mem,
    output logic [PTR_W-1:0]  desc_ptr,
    output logic              walker_start,
    output logic              walker_cancel,
    input  logic              walker_inactive,
    input  logic              walker_more,
    input  logic              walker_error,
    input  logic              irq_in,
    output logic              irq_out
);
    localparam int IMG_W = LANES * 8;

    acc_size_e       size_e;
    lane_wr_t        lanes;
    logic [7:0]      cmd;
    logic [7:0]      status;
    logic            active;
    logic            cancel_req;
    logic [PTR_W-1:0] base;
    logic [IMG_W-1:0] image;

    assign size_e = acc_size_e'(reg_size);

    bmdma_lane_dec u_dec (
        .wr_req (reg_valid && reg_write),
        .ofs    (reg_addr),
        .size   (size_e),
        .wdata  (reg_wdata),
        .lanes  (lanes)
    );

    bmdma_cmd_unit u_cmd (
        .clk             (clk),
        .rst             (rst),
        .wr_en           (lanes.en[CMD_OFS]),
        .wr_byte         (lanes.data[CMD_OFS*8 +: 8]),
        .base            (base),
        .walker_inactive (walker_inactive),
        .walker_more     (walker_more),
        .cmd             (cmd),
        .active          (active),
        .start_req       (walker_start),
        .cancel_req      (cancel_req),
        .cur_ptr         (desc_ptr)
    );

    bmdma_status_unit u_stat (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (lanes.en[STAT_OFS]),
        .wr_byte      (lanes.data[STAT_OFS*8 +: 8]),
        .active       (active),
        .irq_in       (irq_in),
        .walker_error (walker_error),
        .status       (status)
    );

    bmdma_base_reg u_base (
        .clk       (clk),
        .rst       (rst),
        .byte_en   (lanes.en[BASE_OFS +: BASE_BYTES]),
        .byte_data (lanes.data[BASE_OFS*8 +: PTR_W]),
        .base      (base)
    );

    always_comb begin
        image = '0;
        image[CMD_OFS*8 +: 8]    = cmd;
        image[STAT_OFS*8 +: 8]   = status;
        image[BASE_OFS*8 +: PTR_W] = base;
        reg_rdata = image[DATA_W-1:0] >> 0;
        reg_rdata = DATA_W'(image >> (8 * int'(reg_addr))) & size_mask(size_e);
    end

    assign dir_to_mem    = cmd[CMD_DIR_BIT];
    assign walker_cancel = cancel_req || (rst && active);
    assign irq_out       = irq_in;

    // R2
    cmd_kept_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd & ~CMD_KEEP) == 8'h00);
endmodule

// File: tb/bmdma_ctrl_regs_tb.sv
`timescale 1ns/1ps
module bmdma_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [1:0]  reg_size = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dir_to_mem;
    logic [31:0] desc_ptr;
    logic        walker_start;
    logic        walker_cancel;
    logic        walker_inactive = 1'b0;
    logic        walker_more = 1'b0;
    logic        walker_error = 1'b0;
    logic        irq_in = 1'b0;
    logic        irq_out;

    int  vecs = 0;
    int  errs = 0;
    bit  done = 0;

    logic [7:0]  m_cmd  = 8'h00;
    logic [7:0]  m_stat = 8'h00;
    logic [31:0] m_base = 32'h0;
    logic [31:0] m_ptr  = 32'h0;
    logic        m_irq  = 1'b0;

    always #2 clk = ~clk;

    bmdma_ctrl_regs u_dut (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dir_to_mem(dir_to_mem), .desc_ptr(desc_ptr),
        .walker_start(walker_start), .walker_cancel(walker_cancel),
        .walker_inactive(walker_inactive), .walker_more(walker_more),
        .walker_error(walker_error), .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int a, input int s);
        logic [63:0] img;
        logic [63:0] sh;
        logic [31:0] mask;
        img  = {m_base, 8'h00, m_stat, 8'h00, m_cmd};
        sh   = img >> (8 * a);
        mask = (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        return sh[31:0] & mask;
    endfunction

    task automatic read_chk(input string req, input int a, input int s);
        reg_valid = 1'b0;
        reg_write = 1'b0;
        reg_addr  = 3'(a);
        reg_size  = 2'(s);
        #0.2;
        chk(req, reg_rdata, model_read(a, s));
    endtask

    // R7 sweep of every offset and size
    task automatic sweep_reads(input string req);
        for (int a = 0; a < 8; a++) begin
            for (int s = 0; s < 3; s++) begin
                read_chk(req, a, s);
            end
        end
    endtask

    task automatic write_reg(input int a, input int s, input logic [31:0] d);
        logic exp_st;
        logic exp_cn;
        int   n;
        exp_st = 1'b0;
        exp_cn = 1'b0;
        n = 1 << s;
        for (int i = 0; i < n; i++) begin
            int b;
            logic [7:0] v;
            b = a + i;
            v = d[8*i +: 8];
            if (b == 0) begin
                if (v[0] && !m_cmd[0]) begin
                    m_ptr = m_base;
                    if (!m_stat[0]) begin
                        m_stat[0] = 1'b1;
                        exp_st = 1'b1;
                    end
                end else if (!v[0] && m_cmd[0]) begin
                    m_stat[0] = 1'b0;
                    exp_cn = 1'b1;
                end
                m_cmd = v & 8'h09;
            end else if (b == 2) begin
                if (v[1]) m_stat[1] = 1'b0;
                if (v[2]) m_stat[2] = 1'b0;
                m_stat[6:5] = v[6:5];
            end else if (b >= 4 && b < 8) begin
                m_base[8*(b-4) +: 8] = (b == 4) ? (v & 8'hFC) : v;
            end
        end
        @(negedge clk);
        reg_valid = 1'b1;
        reg_write = 1'b1;
        reg_addr  = 3'(a);
        reg_size  = 2'(s);
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_valid = 1'b0;
        reg_write = 1'b0;
        chk(exp_st ? "R4 start pulse" : "R3 no start", {31'd0, walker_start}, {31'd0, exp_st});
        chk(exp_cn ? "R5 cancel pulse" : "R3 no cancel", {31'd0, walker_cancel}, {31'd0, exp_cn});
        chk("R4 desc_ptr", desc_ptr, m_ptr);
        chk("R2 dir_to_mem", {31'd0, dir_to_mem}, {31'd0, m_cmd[3]});
    endtask

    task automatic set_irq(input logic v);
        @(negedge clk);
        irq_in = v;
        #0.2;
        chk("R8 irq_out", {31'd0, irq_out}, {31'd0, v});
        if (v && !m_irq) m_stat[2] = 1'b1;
        m_irq = v;
        @(posedge clk);
        #1;
        read_chk("R8 int bit", 2, 0);
    endtask

    task automatic walker_idle(input logic more);
        @(negedge clk);
        walker_inactive = 1'b1;
        walker_more     = more;
        @(posedge clk);
        #1;
        walker_inactive = 1'b0;
        walker_more     = 1'b0;
        m_stat[0] = more;
        read_chk("R10 active after idle", 2, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        sweep_reads("R1 reset image");
        chk("R1 desc_ptr reset", desc_ptr, 32'h0);
        chk("R1 no cancel", {31'd0, walker_cancel}, 32'd0);

        // R6 / R7 base writes at every offset and width
        for (int a = 4; a < 8; a++) begin
            for (int s = 0; s < 3; s++) begin
                write_reg(a, s, 32'hA5C3_1E77 ^ (32'(a) * 32'h0101_0107) ^ (32'(s) << 9));
                sweep_reads("R6 base partial write");
            end
        end
        write_reg(4, 2, 32'h1234_5677);
        chk("R6 low bits zero", model_read(4, 2), 32'h1234_5674);
        read_chk("R6 base word", 4, 2);

        // R2 R3 R4 R5 command sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            if ((v % 16) == 0) write_reg(4, 2, 32'h0001_0000 * 32'(v) + 32'h0000_8003);
            write_reg(0, 0, 32'(v));
            read_chk("R2 cmd readback", 0, 0);
            read_chk("R4 R5 active", 2, 0);
        end

        // R10 idle reporting, and R4 start with active already set
        write_reg(0, 0, 32'h01);
        walker_idle(1'b0);
        walker_idle(1'b1);
        write_reg(0, 0, 32'h00);
        walker_idle(1'b1);
        write_reg(4, 2, 32'hDEAD_BEE0);
        write_reg(0, 0, 32'h09);
        read_chk("R4 active kept", 2, 0);
        walker_idle(1'b0);

        // R8 interrupt latch and pass-through
        set_irq(1'b1);
        set_irq(1'b0);
        write_reg(2, 0, 32'h04);
        read_chk("R9 int cleared", 2, 0);
        set_irq(1'b1);
        write_reg(2, 0, 32'h00);
        read_chk("R9 write 0 keeps int", 2, 0);
        set_irq(1'b0);

        // R11 error report and R9 clear / flags
        @(negedge clk);
        walker_error = 1'b1;
        @(posedge clk);
        #1;
        walker_error = 1'b0;
        m_stat[1] = 1'b1;
        read_chk("R11 err set", 2, 0);
        write_reg(2, 0, 32'hFF);
        read_chk("R9 w1c and flags", 2, 0);
        write_reg(2, 0, 32'h20);
        read_chk("R9 flag lo", 2, 0);
        write_reg(0, 2, 32'h0040_0000);
        sweep_reads("R9 word write into status");

        // R1 reset while active
        write_reg(0, 0, 32'h00);
        write_reg(0, 0, 32'h01);
        @(negedge clk);
        rst = 1'b1;
        #0.2;
        chk("R1 cancel during reset", {31'd0, walker_cancel}, 32'd1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_cmd = 8'h00; m_stat = 8'h00; m_base = 32'h0; m_ptr = 32'h0; m_irq = 1'b0;
        sweep_reads("R1 after reset");
        chk("R1 desc_ptr cleared", desc_ptr, 32'h0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule